// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two tri-state buses, A and B, with a bidirectional link whose width is a parameter. Each direction owns a storage register with its own capture clock, a select input and an output enable. The driver facing a bus carries either the live word from the opposite bus or that direction's stored word, and both paths deliver the bitwise complement of what they carry. The registers always hold the true, uninverted bus value.

Each bus appears at the ports as three vectors: the value seen on the wire, the value the block would drive, and a per-bit drive enable. The surrounding logic or testbench resolves the wire. The A-to-B driver enables on a high level and the B-to-A driver enables on a low level, so one pair of levels leaves both buses undriven. Enabling both directions in live mode turns the two inverting paths into a cross-coupled pair that keeps its value after every other source lets go. Enabling both directions in stored mode exchanges the two stored words.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: `b_oe` is all ones when `ab_en` is 1 and all zeros when `ab_en` is 0.
- R2: `a_oe` is all ones when `ba_en_n` is 0 and all zeros when `ba_en_n` is 1. The B-to-A enable is active low.
- R3: With `ab_en` = 0 and `ba_en_n` = 1, neither `a_oe` nor `b_oe` has any bit set, and the buses are isolated.
- R4: On each rising edge of `a_clk` the A register takes `a_in`, and on each rising edge of `b_clk` the B register takes `b_in`. Capture happens whatever the select and enable inputs are.
- R5: With a select at 0, the driven output is the bitwise complement of the live opposite bus: `b_out` = ~`a_in`, `a_out` = ~`b_in`.
- R6: With a select at 1, the driven output is the bitwise complement of that direction's stored word: `b_out` = ~A register, `a_out` = ~B register.
- R7: When the stored B word is driven onto A and `a_clk` rises, the A register takes the driven value, the complement of the B word. The same holds from A to B.
- R8: With both directions enabled and both selects at 0, A and B keep complementary values once every external driver is released.
- R9: With both directions enabled and both selects at 1, A carries ~B register and B carries ~A register at the same time.
- R10: While `rst_n` is 0, both registers clear to zero. A stored read after reset returns all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Capture clock of the A register |
| b_clk | input | 1 | Capture clock of the B register |
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| ab_en | input | 1 | A-to-B driver enable, active high |
| ba_en_n | input | 1 | B-to-A driver enable, active low |
| ab_sel | input | 1 | A-to-B source: 0 live, 1 stored |
| ba_sel | input | 1 | B-to-A source: 0 live, 1 stored |
| a_in | input | W | Resolved value on bus A |
| a_out | output | W | Value driven toward bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_in | input | W | Resolved value on bus B |
| b_out | output | W | Value driven toward bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
The assertions sample at the two capture clocks. They assume that the bus inputs and controls are steady around each edge and that each bus input has exactly one source, either the block or an outside driver. The stimulus changes inputs only between edges. It resolves each bus in a settling loop that gives a driven block output priority, otherwise takes an enabled external source, and otherwise keeps the last value. Each external source is switched off in the same step that turns on the block's driver for that bus, so the two never overlap.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    PATH_LIVE   = 1'b0,
    PATH_STORED = 1'b1
  } path_sel_e;
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  // every edge captures: no hold condition exists
  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  path_sel_e    sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y_inv
);
  logic [W-1:0] picked;

  always_comb begin
    unique case (sel)
      PATH_STORED: picked = stored;
      default:     picked = live;
    endcase
    // inversion sits after the mux so both sources come out complemented
    y_inv = ~picked;
  end
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl #(
  parameter int W       = 8,
  parameter bit EN_HIGH = 1'b1
) (
  input  logic         en,
  output logic [W-1:0] oe
);
  logic active;

  generate
    if (EN_HIGH) begin : g_high
      assign active = en;
    end else begin : g_low
      assign active = ~en;
    end
  endgenerate

  assign oe = {W{active}};
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W       = 8,
  parameter bit EN_HIGH = 1'b1
) (
  input  logic         cap_clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_bus,
  input  logic         sel,
  input  logic         en,
  output logic [W-1:0] dst_out,
  output logic [W-1:0] dst_oe,
  output logic [W-1:0] held
);
  path_sel_e path;

  assign path = path_sel_e'(sel);

  xcvr_store_reg #(.W(W)) i_store (
    .clk   (cap_clk),
    .rst_n (rst_n),
    .d     (src_bus),
    .q     (held)
  );

  xcvr_path_mux #(.W(W)) i_mux (
    .sel    (path),
    .live   (src_bus),
    .stored (held),
    .y_inv  (dst_out)
  );

  xcvr_drive_ctl #(.W(W), .EN_HIGH(EN_HIGH)) i_drv (
    .en (en),
    .oe (dst_oe)
  );
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
  parameter int W = 8
) (
  input  logic         a_clk,
  input  logic         b_clk,
  input  logic         rst_n,
  input  logic         ab_en,
  input  logic         ba_en_n,
  input  logic         ab_sel,
  input  logic         ba_sel,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  logic [W-1:0] a_store;
  logic [W-1:0] b_store;

  // A side: captures bus A, drives bus B, enable active high
  xcvr_lane #(.W(W), .EN_HIGH(1'b1)) i_lane_ab (
    .cap_clk (a_clk),
    .rst_n   (rst_n),
    .src_bus (a_in),
    .sel     (ab_sel),
    .en      (ab_en),
    .dst_out (b_out),
    .dst_oe  (b_oe),
    .held    (a_store)
  );

  // B side: captures bus B, drives bus A, enable active low
  xcvr_lane #(.W(W), .EN_HIGH(1'b0)) i_lane_ba (
    .cap_clk (b_clk),
    .rst_n   (rst_n),
    .src_bus (b_in),
    .sel     (ba_sel),
    .en      (ba_en_n),
    .dst_out (a_out),
    .dst_oe  (a_oe),
    .held    (b_store)
  );
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 8
) (
  input logic         a_clk,
  input logic         b_clk,
  input logic         rst_n,
  input logic         ab_en,
  input logic         ba_en_n,
  input logic         ab_sel,
  input logic         ba_sel,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic [W-1:0] a_store,
  input logic [W-1:0] b_store
);
  // R1
  ab_enable_level_chk: assert property (@(posedge b_clk) disable iff (!rst_n)
    b_oe == {W{ab_en}});

  // R2
  ba_enable_level_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
    a_oe == {W{~ba_en_n}});

  // R3
  isolation_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
    (!ab_en && ba_en_n) |-> (a_oe == '0 && b_oe == '0));

  // R4
  a_capture_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
    1'b1 |=> a_store == $past(a_in));

  // R4
  b_capture_chk: assert property (@(posedge b_clk) disable iff (!rst_n)
    1'b1 |=> b_store == $past(b_in));

  // R5
  ab_live_chk: assert property (@(posedge b_clk) disable iff (!rst_n)
    (ab_en && !ab_sel) |-> b_out == ~a_in);

  // R5
  ba_live_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
    (!ba_en_n && !ba_sel) |-> a_out == ~b_in);

  // R6
  ab_stored_chk: assert property (@(posedge b_clk) disable iff (!rst_n)
    (ab_en && ab_sel) |-> b_out == ~a_store);

  // R6
  ba_stored_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
    (!ba_en_n && ba_sel) |-> a_out == ~b_store);
endmodule

bind bidir_reg_xcvr xcvr_chk #(.W(W)) i_xcvr_chk (
  .a_clk   (a_clk),
  .b_clk   (b_clk),
  .rst_n   (rst_n),
  .ab_en   (ab_en),
  .ba_en_n (ba_en_n),
  .ab_sel  (ab_sel),
  .ba_sel  (ba_sel),
  .a_in    (a_in),
  .a_out   (a_out),
  .a_oe    (a_oe),
  .b_in    (b_in),
  .b_out   (b_out),
  .b_oe    (b_oe),
  .a_store (a_store),
  .b_store (b_store)
);

// File: tb/test_bidir_reg_xcvr.sv
module test_bidir_reg_xcvr;
  localparam int W          = 8;
  localparam int CLK_PERIOD = 10;

  logic         a_clk, b_clk, rst_n;
  logic         ab_en, ba_en_n, ab_sel, ba_sel;
  logic [W-1:0] a_bus, b_bus;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  // external sources on each bus
  logic         ext_a_en, ext_b_en;
  logic [W-1:0] ext_a, ext_b;

  int checks = 0;
  int fails  = 0;

  bidir_reg_xcvr #(.W(W)) i_bidir_reg_xcvr (
    .a_clk(a_clk), .b_clk(b_clk), .rst_n(rst_n),
    .ab_en(ab_en), .ba_en_n(ba_en_n), .ab_sel(ab_sel), .ba_sel(ba_sel),
    .a_in(a_bus), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_bus), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // resolve both buses; the block's driver wins, then external, else keep
  task automatic settle();
    for (int i = 0; i < 4; i++) begin
      #1;
      if (a_oe != '0)    a_bus = a_out;
      else if (ext_a_en) a_bus = ext_a;
      if (b_oe != '0)    b_bus = b_out;
      else if (ext_b_en) b_bus = ext_b;
    end
    if ((a_oe != '0 && ext_a_en) || (b_oe != '0 && ext_b_en)) begin
      checks++;
      fails++;
      $display("FAIL contention: got a_oe=%h b_oe=%h expected no overlap", a_oe, b_oe);
    end
  endtask

  task automatic pulse_a();
    a_clk = 1'b1; #(CLK_PERIOD/2);
    a_clk = 1'b0; #(CLK_PERIOD/2);
    settle();
  endtask

  task automatic pulse_b();
    b_clk = 1'b1; #(CLK_PERIOD/2);
    b_clk = 1'b0; #(CLK_PERIOD/2);
    settle();
  endtask

  task automatic go_isolated();
    ab_en = 1'b0; ba_en_n = 1'b1;
    settle();
  endtask

  task automatic load_both(input logic [W-1:0] va, input logic [W-1:0] vb);
    go_isolated();
    ext_a_en = 1'b1; ext_a = va;
    ext_b_en = 1'b1; ext_b = vb;
    settle();
    pulse_a();
    pulse_b();
  endtask

  task automatic t_reset_state();
    ext_a_en = 1'b0; ext_b_en = 1'b0;
    ab_en = 1'b1; ab_sel = 1'b1; ba_en_n = 1'b0; ba_sel = 1'b1;
    settle();
    check("R10 stored A after reset", b_bus, '1);
    check("R10 stored B after reset", a_bus, '1);
  endtask

  task automatic t_isolation();
    go_isolated();
    check("R3 a_oe isolated", a_oe, '0);
    check("R3 b_oe isolated", b_oe, '0);
    ab_en = 1'b1; settle();
    check("R1 b_oe on high", b_oe, '1);
    check("R2 a_oe off high", a_oe, '0);
    ab_en = 1'b0; ext_a_en = 1'b0; ba_en_n = 1'b0; settle();
    check("R2 a_oe on low", a_oe, '1);
    check("R1 b_oe off low", b_oe, '0);
  endtask

  task automatic t_store_each_side();
    ab_sel = 1'b0; ba_sel = 1'b1;
    load_both(8'h3C, 8'h5A);
    ext_b_en = 1'b0; ab_en = 1'b1; ab_sel = 1'b1; settle();
    check("R4 R6 stored A on B", b_bus, 8'hC3);
    ab_en = 1'b0; ext_a_en = 1'b0; ba_en_n = 1'b0; ba_sel = 1'b1; settle();
    check("R4 R6 stored B on A", a_bus, 8'hA5);
    // capture while A-to-B stored read is active
    go_isolated();
    ext_a_en = 1'b1; ext_a = 8'h11; ab_en = 1'b1; ab_sel = 1'b1; settle();
    pulse_a();
    check("R4 capture regardless of enable", b_bus, 8'hEE);
  endtask

  task automatic t_live();
    go_isolated();
    ext_a_en = 1'b1; ext_a = 8'h96; ext_b_en = 1'b0;
    ab_en = 1'b1; ab_sel = 1'b0; settle();
    check("R5 live A to B", b_bus, 8'h69);
    ext_a = 8'h01; settle();
    check("R5 live A to B follows", b_bus, 8'hFE);
    go_isolated();
    ext_a_en = 1'b0; ext_b_en = 1'b1; ext_b = 8'h70;
    ba_en_n = 1'b0; ba_sel = 1'b0; settle();
    check("R5 live B to A", a_bus, 8'h8F);
  endtask

  task automatic t_store_through();
    // A register takes the stored B word driven onto A
    load_both(8'h00, 8'h5A);
    ext_a_en = 1'b0; ba_en_n = 1'b0; ba_sel = 1'b1; settle();
    pulse_a();
    ba_en_n = 1'b1; ext_b_en = 1'b0; ab_en = 1'b1; ab_sel = 1'b1; settle();
    check("R7 A reg holds driven B word", b_bus, 8'h5A);
    // B register takes the stored A word (A5) driven onto B
    ab_en = 1'b0; ext_b_en = 1'b1; ext_b = 8'h0F; settle();
    pulse_b();
    ext_b_en = 1'b0; ab_en = 1'b1; settle();
    pulse_b();
    ab_en = 1'b0; ba_en_n = 1'b0; ba_sel = 1'b1; settle();
    check("R7 B reg holds driven A word", a_bus, 8'hA5);
  endtask

  task automatic t_both_stored();
    load_both(8'h12, 8'h34);
    ext_a_en = 1'b0; ext_b_en = 1'b0;
    ab_en = 1'b1; ab_sel = 1'b1; ba_en_n = 1'b0; ba_sel = 1'b1; settle();
    check("R9 B carries stored A", b_bus, 8'hED);
    check("R9 A carries stored B", a_bus, 8'hCB);
  endtask

  task automatic t_hold_loop();
    go_isolated();
    ext_a_en = 1'b1; ext_a = 8'h5C; ext_b_en = 1'b0;
    ab_en = 1'b1; ab_sel = 1'b0; settle();
    check("R5 loop setup B", b_bus, 8'hA3);
    ext_a_en = 1'b0; ba_en_n = 1'b0; ba_sel = 1'b0; settle();
    check("R8 A held", a_bus, 8'h5C);
    check("R8 B held", b_bus, 8'hA3);
    pulse_a();
    pulse_b();
    check("R8 A held after clocks", a_bus, 8'h5C);
    check("R8 B held after clocks", b_bus, 8'hA3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    a_clk = 1'b0; b_clk = 1'b0; rst_n = 1'b0;
    ab_en = 1'b0; ba_en_n = 1'b1; ab_sel = 1'b0; ba_sel = 1'b0;
    ext_a_en = 1'b1; ext_a = 8'h00; ext_b_en = 1'b1; ext_b = 8'h00;
    a_bus = '0; b_bus = '0;
    settle();
    #(CLK_PERIOD);
    rst_n = 1'b1;
    settle();
    t_reset_state();
    t_isolation();
    t_store_each_side();
    t_live();
    t_store_through();
    t_both_stored();
    t_hold_loop();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule